// File: doc/BRIEF.md
# Status Word Flag Register

This block holds the condition flags of a 16-bit processor core and packs them into one status word. After an arithmetic, compare or logical operation, the ALU presents its result, a carry-or-borrow bit, a signed-overflow bit, the operation class and the operand width. On the next clock edge the block updates carry, overflow, sticky overflow trap, negative and zero from those inputs. The width can be byte, word or long.

The block also carries out explicit flag commands: set carry, clear carry, clear the trap, the two trap-testing jumps, and interrupt enable or disable. It can also load the whole word when flags are popped from the stack.

Multi-precision arithmetic is supported in two ways. For add-with-carry and subtract-with-borrow, the zero flag can only be cleared, so after a chain it describes the whole wide result. The overflow trap flag stays set until software explicitly clears it, so a long sequence of operations can be tested for overflow once at the end.

Top module: `psw_flag_unit`

## Requirements
- R1: While reset is asserted, and after reset, all flags are 0 and `psw_word` is 0.
- R2: For op classes ADD=1, SUB=3, CMP=5 and LOGIC=6, Z is set exactly when the result, masked to the operand width, is zero. Result bits above that width are ignored. The width codes are byte=0 (bits 7:0), word=1 (bits 15:0) and long=2 or 3 (bits 31:0).
- R3: For ADDC=2 and SUBB=4, Z is cleared when the masked result is nonzero. Otherwise Z keeps its value; these classes never set Z.
- R4: For ADD and ADDC, C equals `alu_cb`, which is the carry out. For SUB, SUBB and CMP, `alu_cb` is the borrow and C is its complement. LOGIC clears C.
- R5: For arithmetic classes, V equals `alu_ovf`, and LOGIC clears V. VT is set whenever V is set by an update and is never cleared by an update.
- R6: VT is cleared only by these commands: clear-trap=3, jump-on-trap=4 and jump-on-no-trap=5. Other commands and updates leave a set VT at 1.
- R7: For arithmetic classes, N is the most significant bit of the width-masked result (bit 7, 15 or 31) XOR `alu_ovf`. For LOGIC, N is that bit alone.
- R8: Command enable-interrupts=6 sets IE and command disable-interrupts=7 clears it. IE appears at bit 9 of `psw_word`.
- R9: When `load_en` is high, all flags are taken from `load_word` at the positions in R12. This overrides any command or update in the same cycle. Bit 5 and all other unassigned bits read back as 0.
- R10: A command given in the same cycle as an update decides the flag it targets: set-carry=1 and clear-carry=2 decide C, and commands 3 to 5 decide VT. Flags the command does not target still take their update values.
- R11: With `upd_en` low, or with op class NONE=0 or 7, and with command 0 and no load, every flag keeps its value.
- R12: `psw_word` holds C at bit 0, V at bit 1, VT at bit 2, N at bit 3, Z at bit 4 and IE at bit 9. Bit 5 (reserved) and every other bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_en | input | 1 | Apply an ALU flag update this cycle |
| op_class | input | 3 | Operation class code (R2 to R5) |
| op_width | input | 2 | Operand width code (R2) |
| alu_result | input | 32 | ALU result |
| alu_cb | input | 1 | Carry out for adds, borrow for subtracts |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| flag_cmd | input | 3 | Explicit flag command code (R6, R8, R10) |
| load_en | input | 1 | Load the whole status word (flag pop) |
| load_word | input | 16 | Status word to load |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_vt | output | 1 | Sticky overflow trap flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_ie | output | 1 | Interrupt enable flag; when clear, all but the non-maskable interrupt are held off |
| psw_word | output | 16 | Packed status word |

## Verification
The bench applies results whose low byte is zero but whose upper bits are not. A design that ignored the width mask would clear Z in these cases. It runs add-with-carry chains with a zero partial result after a nonzero one; a design that treated these like plain adds would set Z again. Subtracts are run with and without borrow, which exposes an inverted carry. Overflowing adds exercise N: a design that copied the result MSB would report the wrong sign. The bench also checks that VT survives later clean operations and is cleared by each of the three trap commands. Finally, it checks command-against-update and load-against-command collisions, which expose a wrong priority order.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 16;
  localparam int BIT_C  = 0;
  localparam int BIT_V  = 1;
  localparam int BIT_VT = 2;
  localparam int BIT_N  = 3;
  localparam int BIT_Z  = 4;
  localparam int BIT_IE = 9;

  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_ADD   = 3'd1,
    OPC_ADDC  = 3'd2,
    OPC_SUB   = 3'd3,
    OPC_SUBB  = 3'd4,
    OPC_CMP   = 3'd5,
    OPC_LOGIC = 3'd6,
    OPC_RSVD  = 3'd7
  } opc_e;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_SETC  = 3'd1,
    FC_CLRC  = 3'd2,
    FC_CLRVT = 3'd3,
    FC_JVT   = 3'd4,
    FC_JNVT  = 3'd5,
    FC_EI    = 3'd6,
    FC_DI    = 3'd7
  } fcmd_e;

  typedef struct packed {
    logic ie;
    logic z;
    logic n;
    logic vt;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/psw_width_sel.sv
module psw_width_sel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic [1:0]        width,
  output logic              msb,
  output logic              is_zero
);
  localparam int NLANE = 3;

  function automatic int lane_width(input int k);
    return (k == 0) ? 8 : ((k == 1) ? 16 : DATA_W);
  endfunction

  logic [NLANE-1:0] lane_msb;
  logic [NLANE-1:0] lane_zero;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int LW = lane_width(k);
    assign lane_msb[k]  = result[LW-1];
    assign lane_zero[k] = ~|result[LW-1:0];
  end

  always_comb begin
    unique case (width)
      2'd0:    begin msb = lane_msb[0]; is_zero = lane_zero[0]; end
      2'd1:    begin msb = lane_msb[1]; is_zero = lane_zero[1]; end
      default: begin msb = lane_msb[2]; is_zero = lane_zero[2]; end
    endcase
  end
endmodule

// File: rtl/psw_flag_next.sv
module psw_flag_next
  import psw_pkg::*;
(
  input  flags_t     cur,
  input  logic       upd_en,
  input  logic [2:0] op_class,
  input  logic       msb,
  input  logic       is_zero,
  input  logic       alu_cb,
  input  logic       alu_ovf,
  output flags_t     nxt
);
  opc_e opc;
  logic is_add, is_sub, is_chain, is_logic;

  always_comb begin
    opc      = opc_e'(op_class);
    is_add   = (opc == OPC_ADD) || (opc == OPC_ADDC);
    is_sub   = (opc == OPC_SUB) || (opc == OPC_SUBB) || (opc == OPC_CMP);
    is_chain = (opc == OPC_ADDC) || (opc == OPC_SUBB);
    is_logic = (opc == OPC_LOGIC);
  end

  always_comb begin
    nxt = cur;
    if (upd_en) begin
      if (is_add || is_sub) begin
        nxt.c  = is_add ? alu_cb : ~alu_cb;
        nxt.v  = alu_ovf;
        nxt.vt = cur.vt | alu_ovf;
        nxt.n  = msb ^ alu_ovf;
        nxt.z  = is_chain ? (cur.z & is_zero) : is_zero;
      end else if (is_logic) begin
        nxt.c = 1'b0;
        nxt.v = 1'b0;
        nxt.n = msb;
        nxt.z = is_zero;
      end
    end
  end
endmodule

// File: rtl/psw_ctl_merge.sv
module psw_ctl_merge
  import psw_pkg::*;
(
  input  flags_t             upd,
  input  logic [2:0]         flag_cmd,
  input  logic               load_en,
  input  logic [PSW_W-1:0]   load_word,
  output flags_t             nxt
);
  fcmd_e cmd;

  always_comb begin
    cmd = fcmd_e'(flag_cmd);
    nxt = upd;
    unique case (cmd)
      FC_SETC:                    nxt.c  = 1'b1;
      FC_CLRC:                    nxt.c  = 1'b0;
      FC_CLRVT, FC_JVT, FC_JNVT:  nxt.vt = 1'b0;
      FC_EI:                      nxt.ie = 1'b1;
      FC_DI:                      nxt.ie = 1'b0;
      default:                    ;
    endcase
    if (load_en) begin
      nxt.c  = load_word[BIT_C];
      nxt.v  = load_word[BIT_V];
      nxt.vt = load_word[BIT_VT];
      nxt.n  = load_word[BIT_N];
      nxt.z  = load_word[BIT_Z];
      nxt.ie = load_word[BIT_IE];
    end
  end
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [2:0]        op_class,
  input  logic [1:0]        op_width,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_cb,
  input  logic              alu_ovf,
  input  logic [2:0]        flag_cmd,
  input  logic              load_en,
  input  logic [PSW_W-1:0]  load_word,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flag_vt,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_ie,
  output logic [PSW_W-1:0]  psw_word
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       res_msb, res_zero;
  logic       flags_en;
  flags_t     flags_q, flags_upd, flags_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  psw_width_sel #(.DATA_W(DATA_W)) i_width_sel (
    .result  (alu_result),
    .width   (op_width),
    .msb     (res_msb),
    .is_zero (res_zero)
  );

  psw_flag_next i_flag_next (
    .cur      (flags_q),
    .upd_en   (upd_en),
    .op_class (op_class),
    .msb      (res_msb),
    .is_zero  (res_zero),
    .alu_cb   (alu_cb),
    .alu_ovf  (alu_ovf),
    .nxt      (flags_upd)
  );

  psw_ctl_merge i_ctl_merge (
    .upd       (flags_upd),
    .flag_cmd  (flag_cmd),
    .load_en   (load_en),
    .load_word (load_word),
    .nxt       (flags_d)
  );

  assign flags_en = upd_en | load_en | (flag_cmd != 3'd0);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  always_comb begin
    flag_c  = flags_q.c;
    flag_v  = flags_q.v;
    flag_vt = flags_q.vt;
    flag_n  = flags_q.n;
    flag_z  = flags_q.z;
    flag_ie = flags_q.ie;
    psw_word         = '0;
    psw_word[BIT_C]  = flags_q.c;
    psw_word[BIT_V]  = flags_q.v;
    psw_word[BIT_VT] = flags_q.vt;
    psw_word[BIT_N]  = flags_q.n;
    psw_word[BIT_Z]  = flags_q.z;
    psw_word[BIT_IE] = flags_q.ie;
  end
endmodule

// File: rtl/psw_flag_unit_chk.sv
module psw_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_en,
  input logic [2:0] op_class,
  input logic       alu_cb,
  input logic       alu_ovf,
  input logic [2:0] flag_cmd,
  input logic       load_en,
  input logic       flag_c,
  input logic       flag_vt,
  input logic       flag_z,
  input logic       flag_ie,
  input logic [15:0] psw_word
);
  logic arith, subcls, chain, c_cmd, vt_cmd;
  always_comb begin
    arith  = (op_class >= 3'd1) && (op_class <= 3'd5);
    subcls = (op_class == 3'd3) || (op_class == 3'd4) || (op_class == 3'd5);
    chain  = (op_class == 3'd2) || (op_class == 3'd4);
    c_cmd  = (flag_cmd == 3'd1) || (flag_cmd == 3'd2);
    vt_cmd = (flag_cmd == 3'd3) || (flag_cmd == 3'd4) || (flag_cmd == 3'd5);
  end

  AST_CHAIN_NO_SET_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && chain && !flag_z && !load_en) |=> !flag_z); // R3

  AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && subcls && !c_cmd && !load_en) |=> (flag_c == !$past(alu_cb))); // R4

  AST_OVF_SETS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && arith && alu_ovf && !vt_cmd && !load_en) |=> flag_vt); // R5

  AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_vt && !vt_cmd && !load_en) |=> flag_vt); // R6

  AST_IE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cmd == 3'd6 && !load_en) |=> (flag_ie && psw_word[9])); // R8

  AST_SETC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cmd == 3'd1 && !load_en) |=> flag_c); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((!upd_en || op_class == 3'd0 || op_class == 3'd7) && flag_cmd == 3'd0 && !load_en)
      |=> $stable(psw_word)); // R11
endmodule

bind psw_flag_unit psw_flag_unit_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .upd_en   (upd_en),
  .op_class (op_class),
  .alu_cb   (alu_cb),
  .alu_ovf  (alu_ovf),
  .flag_cmd (flag_cmd),
  .load_en  (load_en),
  .flag_c   (flag_c),
  .flag_vt  (flag_vt),
  .flag_z   (flag_z),
  .flag_ie  (flag_ie),
  .psw_word (psw_word)
);

// File: tb/test_psw_flag_unit.sv
`timescale 1ns/1ps
module test_psw_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_en;
  logic [2:0]  op_class;
  logic [1:0]  op_width;
  logic [31:0] alu_result;
  logic        alu_cb, alu_ovf;
  logic [2:0]  flag_cmd;
  logic        load_en;
  logic [15:0] load_word;
  logic        flag_c, flag_v, flag_vt, flag_n, flag_z, flag_ie;
  logic [15:0] psw_word;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  psw_flag_unit i_psw_flag_unit (
    .clk, .rst_n, .upd_en, .op_class, .op_width, .alu_result, .alu_cb,
    .alu_ovf, .flag_cmd, .load_en, .load_word, .flag_c, .flag_v, .flag_vt,
    .flag_n, .flag_z, .flag_ie, .psw_word
  );

  function automatic logic [15:0] mk(input logic c, v, vt, n, z, ie);
    logic [15:0] w;
    w = '0;
    w[0] = c; w[1] = v; w[2] = vt; w[3] = n; w[4] = z; w[9] = ie;
    return w;
  endfunction

  task automatic chk(input string req, input logic [15:0] exp);
    logic [15:0] act;
    logic [15:0] fl;
    act = psw_word;
    fl  = mk(flag_c, flag_v, flag_vt, flag_n, flag_z, flag_ie);
    n_run++;
    if (act !== exp || fl !== exp) begin
      n_fail++;
      $display("FAIL %s: psw=%h flags=%h expected %h", req, act, fl, exp);
    end
  endtask

  task automatic idle();
    upd_en = 0; op_class = 0; op_width = 0; alu_result = 0; alu_cb = 0;
    alu_ovf = 0; flag_cmd = 0; load_en = 0; load_word = 0;
  endtask

  task automatic drive(input logic u, input logic [2:0] op, input logic [1:0] w,
                       input logic [31:0] r, input logic cb, input logic ov,
                       input logic [2:0] c, input logic ld, input logic [15:0] lw);
    @(negedge clk);
    upd_en = u; op_class = op; op_width = w; alu_result = r; alu_cb = cb;
    alu_ovf = ov; flag_cmd = c; load_en = ld; load_word = lw;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic preset(input logic [15:0] w);
    drive(0, 0, 0, 0, 0, 0, 0, 1, w);
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle();
    repeat (3) @(posedge clk);
    #1 chk("R1 during reset", 16'h0000);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #1 chk("R1 after reset", 16'h0000);
  endtask

  task automatic t_width_zero();
    preset(16'h0000);
    drive(1, 3'd1, 2'd0, 32'h0000_0100, 1, 0, 0, 0, 0);
    chk("R2 byte zero with upper bits set, R4 add carry", mk(1,0,0,0,1,0));
    drive(1, 3'd6, 2'd1, 32'h0001_8000, 0, 0, 0, 0, 0);
    chk("R7 logic word msb, R2 nonzero", mk(0,0,0,1,0,0));
    drive(1, 3'd6, 2'd2, 32'h0000_0000, 0, 0, 0, 0, 0);
    chk("R2 long zero", mk(0,0,0,0,1,0));
    drive(1, 3'd6, 2'd0, 32'h0000_0080, 0, 0, 0, 0, 0);
    chk("R7 byte msb bit 7", mk(0,0,0,1,0,0));
  endtask

  task automatic t_sub_carry();
    preset(16'h0000);
    drive(1, 3'd3, 2'd1, 32'h0000_0005, 1, 0, 0, 0, 0);
    chk("R4 sub with borrow clears C", mk(0,0,0,0,0,0));
    drive(1, 3'd5, 2'd1, 32'h0000_0000, 0, 0, 0, 0, 0);
    chk("R4 cmp no borrow sets C, R2 zero", mk(1,0,0,0,1,0));
    drive(1, 3'd6, 2'd1, 32'h0000_0001, 0, 0, 0, 0, 0);
    chk("R4 logic clears C", mk(0,0,0,0,0,0));
  endtask

  task automatic t_overflow();
    preset(16'h0000);
    drive(1, 3'd1, 2'd1, 32'h0000_8000, 0, 1, 0, 0, 0);
    chk("R5 V and VT set, R7 N corrected", mk(0,1,1,0,0,0));
    drive(1, 3'd6, 2'd1, 32'h0000_0001, 0, 0, 0, 0, 0);
    chk("R5 logic clears V, R6 VT kept", mk(0,0,1,0,0,0));
    drive(1, 3'd1, 2'd1, 32'h0000_0002, 0, 0, 3'd1, 0, 0);
    chk("R6 VT kept through clean add and set-carry", mk(1,0,1,0,0,0));
    drive(0, 0, 0, 0, 0, 0, 3'd5, 0, 0);
    chk("R6 jump-on-no-trap clears VT", mk(1,0,0,0,0,0));
    preset(16'h0004);
    drive(0, 0, 0, 0, 0, 0, 3'd4, 0, 0);
    chk("R6 jump-on-trap clears VT", mk(0,0,0,0,0,0));
    preset(16'h0004);
    drive(0, 0, 0, 0, 0, 0, 3'd3, 0, 0);
    chk("R6 clear-trap clears VT", mk(0,0,0,0,0,0));
  endtask

  task automatic t_chain();
    preset(16'h0000);
    drive(1, 3'd1, 2'd2, 32'h0000_0000, 1, 0, 0, 0, 0);
    chk("R2 low half zero", mk(1,0,0,0,1,0));
    drive(1, 3'd2, 2'd2, 32'h0000_0000, 0, 0, 0, 0, 0);
    chk("R3 addc zero keeps Z set", mk(0,0,0,0,1,0));
    drive(1, 3'd2, 2'd2, 32'h0000_0005, 0, 0, 0, 0, 0);
    chk("R3 addc nonzero clears Z", mk(0,0,0,0,0,0));
    drive(1, 3'd2, 2'd2, 32'h0000_0000, 0, 0, 0, 0, 0);
    chk("R3 addc zero does not set Z", mk(0,0,0,0,0,0));
    drive(1, 3'd4, 2'd0, 32'h0000_0000, 0, 0, 0, 0, 0);
    chk("R3 subb zero does not set Z, R4 no borrow", mk(1,0,0,0,0,0));
  endtask

  task automatic t_ie();
    preset(16'h0000);
    drive(0, 0, 0, 0, 0, 0, 3'd6, 0, 0);
    chk("R8 enable interrupts bit 9", mk(0,0,0,0,0,1));
    drive(1, 3'd6, 2'd1, 32'h0, 0, 0, 0, 0, 0);
    chk("R8 IE kept across update", mk(0,0,0,0,1,1));
    drive(0, 0, 0, 0, 0, 0, 3'd7, 0, 0);
    chk("R8 disable interrupts", mk(0,0,0,0,1,0));
  endtask

  task automatic t_priority();
    preset(16'h0000);
    drive(1, 3'd1, 2'd1, 32'h0000_0000, 0, 0, 3'd1, 0, 0);
    chk("R10 set-carry beats add carry, Z still updated", mk(1,0,0,0,1,0));
    drive(1, 3'd1, 2'd1, 32'h0000_8000, 1, 1, 3'd3, 0, 0);
    chk("R10 clear-trap beats overflow update", mk(1,1,0,0,0,0));
    drive(1, 3'd3, 2'd1, 32'h0000_0001, 0, 0, 3'd2, 0, 0);
    chk("R10 clear-carry beats sub carry", mk(0,0,0,0,0,0));
  endtask

  task automatic t_load();
    preset(16'hFFFF);
    chk("R9 load all ones, R12 reserved bits zero", 16'h021F);
    drive(1, 3'd6, 2'd1, 32'h0000_0000, 0, 0, 3'd6, 1, 16'h0011);
    chk("R9 load beats command and update", mk(1,0,0,0,1,0));
    preset(16'h0220);
    chk("R9 X bit dropped, IE loaded", mk(0,0,0,0,0,1));
  endtask

  task automatic t_idle();
    preset(16'h0013);
    drive(0, 3'd1, 2'd1, 32'h0000_1234, 0, 1, 0, 0, 0);
    chk("R11 upd_en low holds", 16'h0013);
    drive(1, 3'd0, 2'd1, 32'h0000_1234, 0, 1, 0, 0, 0);
    chk("R11 class NONE holds", 16'h0013);
    drive(1, 3'd7, 2'd1, 32'h0000_1234, 0, 1, 0, 0, 0);
    chk("R11 class 7 holds", 16'h0013);
  endtask

  initial begin
    t_reset();
    t_width_zero();
    t_sub_carry();
    t_overflow();
    t_chain();
    t_ie();
    t_priority();
    t_load();
    t_idle();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule